// File: doc/BRIEF.md
# Key-Chord Hold Reset Detector

This block watches four active-high key lines and asks for a system reset when a chosen group of them has been held high together for long enough. Two static settings shape it. The first picks the chord: off, the two lowest keys, the three lowest keys, or all four. The second picks the hold time from four lengths, given as tick counts of the timebase clock. The defaults cover 4 s, 2 s, 250 ms and 62.5 ms at 32.768 kHz.

The key lines are asynchronous, so each one first passes through a two-flop synchronizer. A single counter then counts how long the chord has been held without a break. The reset request rises once the count reaches the selected length. It stays high while the chord is still held and falls as soon as any key in the chord is released.

Top module: `keychord_reset`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it goes high, `rst_req` is 0 and the hold count is zero.
- R2: With `chord_sel` = 0 (off), `rst_req` stays 0 for any pattern on `keys_in`.
- R3: With `chord_sel` = 1, the chord is `keys_in[1:0]`. Both bits must be high for the hold to count.
- R4: With `chord_sel` = 2, the chord is `keys_in[2:0]`. All three bits must be high.
- R5: With `chord_sel` = 3, the chord is `keys_in[3:0]`. All four bits must be high.
- R6: Keys outside the selected chord have no effect on `rst_req` or on the hold count.
- R7: `hold_sel` picks the hold length: 0 selects HOLD_T0 (longest), 1 selects HOLD_T1, 2 selects HOLD_T2 and 3 selects HOLD_T3. `rst_req` rises on clock edge N+2 after the chord is first sampled high, where N is the selected length.
- R8: If any chord key is seen low before the hold completes, the count returns to zero. A later hold starts again from the beginning.
- R9: After the hold completes, `rst_req` stays 1 while the chord is held. It falls on the third clock edge after a chord key drops.
- R10: Each key line passes through two flip-flops before it is evaluated. A change on `keys_in` first affects the count at the third clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| keys_in | input | 4 | Raw active-high key lines |
| chord_sel | input | 2 | Chord setting: 0 off, 1 keys 1..0, 2 keys 2..0, 3 keys 3..0 |
| hold_sel | input | 2 | Hold length setting: 0 longest through 3 shortest |
| rst_req | output | 1 | Reset request |

## Verification
The bench checks the exact edge at which the request rises. A design that counts one tick too many or too few, or that drops a synchronizer stage, fires one cycle early or late. It releases the chord one cycle short of the full hold and then presses it again. A counter that is not cleared would fire too soon on the second attempt. It toggles keys outside the chord during a hold, which a wrong chord mask would turn into a restart or a false fire. It also holds the chord long after timeout to show that the request stays high, and checks that it falls exactly three edges after a release.

// File: rtl/keychord_reset.sv
module keychord_reset #(
  parameter int HOLD_T0 = 131072,
  parameter int HOLD_T1 = 65536,
  parameter int HOLD_T2 = 8192,
  parameter int HOLD_T3 = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] keys_in,
  input  logic [1:0] chord_sel,
  input  logic [1:0] hold_sel,
  output logic       rst_req
);

  localparam int MAX01 = (HOLD_T0 > HOLD_T1) ? HOLD_T0 : HOLD_T1;
  localparam int MAX23 = (HOLD_T2 > HOLD_T3) ? HOLD_T2 : HOLD_T3;
  localparam int HMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int CW    = $clog2(HMAX + 1);

  logic [3:0]    sync_a, sync_b;
  logic [3:0]    mask;
  logic [CW-1:0] limit;
  logic [CW-1:0] cnt;
  logic          chord_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= keys_in;
      sync_b <= sync_a;
    end
  end

  always_comb begin
    case (chord_sel)
      2'd1:    mask = 4'b0011;
      2'd2:    mask = 4'b0111;
      2'd3:    mask = 4'b1111;
      default: mask = 4'b0000;
    endcase
    case (hold_sel)
      2'd0:    limit = CW'(HOLD_T0);
      2'd1:    limit = CW'(HOLD_T1);
      2'd2:    limit = CW'(HOLD_T2);
      default: limit = CW'(HOLD_T3);
    endcase
  end

  assign chord_on = (mask != 4'b0000) && ((sync_b & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!chord_on)    cnt <= '0;
    else if (cnt < limit)  cnt <= cnt + 1'b1;
  end

  assign rst_req = (cnt >= limit);

endmodule

module keychord_reset_chk #(
  parameter int CW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    chord_sel,
  input logic          chord_on,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] limit,
  input logic          rst_req
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (cnt == '0 && !rst_req));

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chord_sel == 2'd0) |-> !rst_req);

  // R8
  break_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chord_on |=> (cnt == '0));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chord_on && cnt < limit && $stable(limit)) |=> (cnt == $past(cnt) + 1'b1));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !chord_on) |=> !rst_req);

  // R9
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && chord_on && $stable(limit)) |=> rst_req);

endmodule

bind keychord_reset keychord_reset_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .chord_sel(chord_sel), .chord_on(chord_on),
  .cnt(cnt), .limit(limit), .rst_req(rst_req)
);

// File: tb/keychord_reset_tb.sv
module keychord_reset_tb_top;
  localparam int T0 = 48, T1 = 24, T2 = 12, T3 = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] keys_in = '0;
  logic [1:0] chord_sel = '0;
  logic [1:0] hold_sel = '0;
  logic       rst_req;

  int    vectors = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit    q[$];
  int    run = 0;
  bit    expv = 1'b0;

  keychord_reset #(.HOLD_T0(T0), .HOLD_T1(T1), .HOLD_T2(T2), .HOLD_T3(T3)) dut_i (
    .clk(clk), .rst_n(rst_n), .keys_in(keys_in), .chord_sel(chord_sel),
    .hold_sel(hold_sel), .rst_req(rst_req)
  );

  always #5 clk = ~clk;

  function automatic int lim_of(input logic [1:0] h);
    case (h)
      2'd0: return T0;
      2'd1: return T1;
      2'd2: return T2;
      default: return T3;
    endcase
  endfunction

  function automatic bit chord_f(input logic [3:0] k, input logic [1:0] g);
    int n = int'(g) + 1;
    if (g == 2'd0) return 1'b0;
    for (int i = 0; i < n; i++) if (!k[i]) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete();
      run = 0;
    end else begin
      q.push_back(chord_f(keys_in, chord_sel));
      if (q.size() > 2) begin
        bit x;
        x = q.pop_front();
        if (!x) run = 0;
        else if (run < lim_of(hold_sel)) run++;
      end
    end
    expv = (run >= lim_of(hold_sel));
  end

  always @(negedge clk) begin
    vectors++;
    if (rst_req !== expv) begin
      fails++;
      $display("FAIL %s: cycle %0d rst_req=%0b expected=%0b", cur_req, cycles, rst_req, expv);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: cycle %0d rst_req=%0b expected=finish", cycles, rst_req);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] g, input logic [1:0] h);
    @(negedge clk);
    rst_n = 1'b0; keys_in = '0; chord_sel = g; hold_sel = h;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
  endtask

  initial begin
    cur_req = "R1";
    wait_cyc(3);
    do_reset(2'd1, 2'd3);
    wait_cyc(2);

    cur_req = "R2";
    do_reset(2'd0, 2'd3);
    keys_in = 4'hF; wait_cyc(40);
    keys_in = 4'h3; wait_cyc(20);

    cur_req = "R7";
    for (int h = 0; h < 4; h++) begin
      do_reset(2'd1, 2'(h));
      keys_in = 4'h3; wait_cyc(lim_of(2'(h)) + 8);
      keys_in = 4'h0; wait_cyc(6);
    end

    cur_req = "R3";
    do_reset(2'd1, 2'd2);
    keys_in = 4'h1; wait_cyc(30);
    keys_in = 4'h2; wait_cyc(30);
    keys_in = 4'h3; wait_cyc(20);

    cur_req = "R9";
    keys_in = 4'h3; wait_cyc(60);
    keys_in = 4'h1; wait_cyc(8);

    cur_req = "R8";
    do_reset(2'd1, 2'd2);
    keys_in = 4'h3; wait_cyc(T2 - 1);
    keys_in = 4'h0; wait_cyc(1);
    keys_in = 4'h3; wait_cyc(T2 + 6);
    keys_in = 4'h2; wait_cyc(4);

    cur_req = "R10";
    do_reset(2'd1, 2'd3);
    keys_in = 4'h3; wait_cyc(T3 + 3);
    keys_in = 4'h0; wait_cyc(1);
    keys_in = 4'h3; wait_cyc(T3 + 5);

    cur_req = "R4";
    do_reset(2'd2, 2'd3);
    keys_in = 4'h3; wait_cyc(20);
    keys_in = 4'h7; wait_cyc(T3 + 5);
    keys_in = 4'h5; wait_cyc(6);

    cur_req = "R5";
    do_reset(2'd3, 2'd2);
    keys_in = 4'h7; wait_cyc(30);
    keys_in = 4'hF; wait_cyc(T2 + 5);
    keys_in = 4'hB; wait_cyc(6);

    cur_req = "R6";
    do_reset(2'd1, 2'd1);
    keys_in = 4'hC; wait_cyc(40);
    keys_in = 4'h3;
    for (int i = 0; i < T1 + 6; i++) begin
      keys_in[3:2] = 2'(i);
      wait_cyc(1);
    end
    keys_in = 4'h0; wait_cyc(6);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule